// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

This block merges up to four overlay layers into a single stream of output pixels. A raster scanner walks every coordinate of a frame whose width and height come from the display-size inputs. For each coordinate it presents the position to an outside pixel source, which answers in the same cycle with one ARGB value per layer. Every layer carries an enable, a rectangle (origin and extent), a pipe select and a priority.

Composition runs in two steps. First, each of the two pipes picks one pixel: among the enabled layers routed to that pipe whose rectangle contains the coordinate, the one with the greatest priority wins. Second, the pipe 1 result is alpha-blended over the pipe 0 result, which in turn sits on a programmable background color. Pipe 0 is treated as opaque. A hardware quirk is reproduced: when the pipe 0 winner is a priority-0 layer whose alpha is not fully opaque, its pixel is thrown away and the background shows instead.

Top module: `layer_compositor`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `pix_valid` are low and the background color is black (0x000000).
- R2: A `start` pulse while idle with non-zero width W and height H scans W*H pixels in raster order (x fastest, from (0,0)); `out_last` marks only pixel (W-1,H-1); `start` while a frame is in progress, or with a zero size, is ignored.
- R3: A layer covers a pixel when it is enabled (`lay_en` bit i) and X <= x < X+W and Y <= y < Y+H; a disabled or non-covering layer never contributes.
- R4: Within a pipe the covering layer with the largest `lay_prio` wins; on equal priority the lower layer index wins.
- R5: A pipe with no covering layer is transparent; when both pipes are transparent the output is the background color.
- R6: The output is (a*P1 + (255-a)*B + 127)/255 per 8-bit channel, where P1 is the pipe 1 pixel, a its alpha (bits 31:24 of the layer word) and B the pipe 0 result; pipe 1 lies on top regardless of priority.
- R7: If the pipe 0 winner has priority 0 and alpha other than 0xFF, pipe 0 yields the background color; pipe 1 still blends over it.
- R8: The alpha of a pipe 0 winner with non-zero priority has no effect: its RGB is shown unchanged where pipe 1 is transparent.
- R9: A cycle with `bg_wr` high loads `bg_rgb` as the background color used by later pixels.
- R10: The result for a coordinate leaves on `out_*` two clock edges after that coordinate appears on `pix_x`/`pix_y`, carrying the same coordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame scan when idle |
| disp_w | input | COORD_W | Frame width in pixels |
| disp_h | input | COORD_W | Frame height in pixels |
| bg_wr | input | 1 | Load background color |
| bg_rgb | input | 24 | Background color {R,G,B} |
| lay_en | input | NUM_LAYERS | Layer enables, bit i for layer i |
| lay_pipe | input | NUM_LAYERS | Pipe select per layer (0 or 1) |
| lay_prio | input | NUM_LAYERS*PRIO_W | Priority per layer, layer i at slice i |
| lay_x | input | NUM_LAYERS*COORD_W | Layer origin x |
| lay_y | input | NUM_LAYERS*COORD_W | Layer origin y |
| lay_w | input | NUM_LAYERS*COORD_W | Layer width |
| lay_h | input | NUM_LAYERS*COORD_W | Layer height |
| lay_argb | input | NUM_LAYERS*32 | Pixel per layer {A,R,G,B} for the presented coordinate |
| pix_valid | output | 1 | Scanner presents a coordinate |
| pix_x | output | COORD_W | Presented x |
| pix_y | output | COORD_W | Presented y |
| out_valid | output | 1 | Output pixel valid |
| out_last | output | 1 | Final pixel of the frame |
| out_x | output | COORD_W | Output pixel x |
| out_y | output | COORD_W | Output pixel y |
| out_rgb | output | 24 | Composited color {R,G,B} |

## Verification
The bench probes rectangle edges, where an off-by-one comparison would let a layer bleed one column past its extent, and equal priorities, where a non-strict compare would hand the pixel to the higher index. It checks a low-priority pipe 1 layer over a high-priority pipe 0 layer, catching a design that merged the pipes by priority, and alpha values of 0, 128 and 255 so a blend with wrong rounding or swapped operands shows a wrong channel value. The priority-0 translucent quirk is tried alone, under a translucent pipe 1 layer and with a non-black background, and a priority-1 translucent pipe 0 layer checks that the quirk is not applied too widely. Restart requests during a frame and zero-size frames catch a scanner that restarts or emits pixels when it should not.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int NUM_PIPES = 2;
    localparam int CH_W      = 8;
    localparam int ARGB_W    = 4 * CH_W;

    localparam logic [CH_W-1:0] ALPHA_OPAQUE = 8'hFF;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;
endpackage

// File: rtl/lc_scan.sv
// Raster coordinate generator: x runs fastest, one pixel per cycle.
module lc_scan #(
    parameter int COORD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] disp_w,
    input  logic [COORD_W-1:0] disp_h,
    output logic               pix_valid,
    output logic               pix_last,
    output logic [COORD_W-1:0] pix_x,
    output logic [COORD_W-1:0] pix_y
);
    localparam logic [COORD_W-1:0] ONE = 1;

    typedef struct packed {
        logic               busy;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } scan_t;

    scan_t st_d, st_q;
    logic  row_end;
    logic  col_end;
    logic  size_ok;

    assign row_end = (st_q.x == disp_w - ONE);
    assign col_end = (st_q.y == disp_h - ONE);
    assign size_ok = (disp_w != '0) && (disp_h != '0);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start && size_ok) begin
                st_d.busy = 1'b1;
                st_d.x    = '0;
                st_d.y    = '0;
            end
        end else if (row_end) begin
            st_d.x = '0;
            if (col_end) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.y = st_q.y + ONE;
            end
        end else begin
            st_d.x = st_q.x + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_valid = st_q.busy;
    assign pix_last  = st_q.busy && row_end && col_end;
    assign pix_x     = st_q.x;
    assign pix_y     = st_q.y;
endmodule

// File: rtl/lc_pipe_resolve.sv
// Picks the winning layer pixel of one pipe at one coordinate.
module lc_pipe_resolve
    import lc_pkg::*;
#(
    parameter int NUM_LAYERS     = 4,
    parameter int COORD_W        = 8,
    parameter int PRIO_W         = 2,
    parameter bit PIPE_SEL       = 1'b0,
    parameter bit DROP_LOW_ALPHA = 1'b0
) (
    input  logic [NUM_LAYERS-1:0]         lay_en,
    input  logic [NUM_LAYERS-1:0]         lay_pipe,
    input  logic [NUM_LAYERS*PRIO_W-1:0]  lay_prio,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_x,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_y,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_w,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_h,
    input  logic [NUM_LAYERS*ARGB_W-1:0]  lay_argb,
    input  logic [COORD_W-1:0]            pos_x,
    input  logic [COORD_W-1:0]            pos_y,
    output logic                          hit,
    output argb_t                         px
);
    localparam int EXT_W = COORD_W + 1;

    logic [NUM_LAYERS-1:0] covers;
    logic [EXT_W-1:0]      px_ext;
    logic [EXT_W-1:0]      py_ext;

    assign px_ext = {1'b0, pos_x};
    assign py_ext = {1'b0, pos_y};

    for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_cover
        logic [EXT_W-1:0] x0, y0, x1, y1;
        assign x0 = {1'b0, lay_x[i*COORD_W +: COORD_W]};
        assign y0 = {1'b0, lay_y[i*COORD_W +: COORD_W]};
        assign x1 = x0 + {1'b0, lay_w[i*COORD_W +: COORD_W]};
        assign y1 = y0 + {1'b0, lay_h[i*COORD_W +: COORD_W]};
        assign covers[i] = lay_en[i] && (lay_pipe[i] == PIPE_SEL) &&
                           (px_ext >= x0) && (px_ext < x1) &&
                           (py_ext >= y0) && (py_ext < y1);
    end

    logic              found;
    logic [PRIO_W-1:0] best_prio;
    argb_t             best_px;

    // Strict greater-than keeps the lowest index on a priority tie.
    always_comb begin
        found     = 1'b0;
        best_prio = '0;
        best_px   = '0;
        for (int i = 0; i < NUM_LAYERS; i++) begin
            if (covers[i] && (!found || lay_prio[i*PRIO_W +: PRIO_W] > best_prio)) begin
                found     = 1'b1;
                best_prio = lay_prio[i*PRIO_W +: PRIO_W];
                best_px   = argb_t'(lay_argb[i*ARGB_W +: ARGB_W]);
            end
        end
    end

    if (DROP_LOW_ALPHA) begin : g_drop
        // A translucent lowest-priority winner is discarded entirely.
        assign hit = found && !((best_prio == '0) && (best_px.a != ALPHA_OPAQUE));
    end else begin : g_keep
        assign hit = found;
    end

    assign px = best_px;
endmodule

// File: rtl/lc_blend.sv
// Rounded per-channel alpha blend of an upper color over a lower color.
module lc_blend
    import lc_pkg::*;
(
    input  logic [CH_W-1:0] alpha,
    input  rgb_t            upper,
    input  rgb_t            lower,
    output rgb_t            mix
);
    localparam int ACC_W = 2 * CH_W;

    function automatic logic [CH_W-1:0] mix_ch(
        input logic [CH_W-1:0] a,
        input logic [CH_W-1:0] u,
        input logic [CH_W-1:0] l
    );
        logic [ACC_W-1:0] acc;
        acc = ACC_W'(a) * ACC_W'(u) +
              ACC_W'(ALPHA_OPAQUE - a) * ACC_W'(l) +
              ACC_W'(127);
        return CH_W'(acc / ACC_W'(255));
    endfunction

    assign mix.r = mix_ch(alpha, upper.r, lower.r);
    assign mix.g = mix_ch(alpha, upper.g, lower.g);
    assign mix.b = mix_ch(alpha, upper.b, lower.b);
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
    import lc_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int COORD_W    = 8,
    parameter int PRIO_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [COORD_W-1:0]            disp_w,
    input  logic [COORD_W-1:0]            disp_h,
    input  logic                          bg_wr,
    input  logic [23:0]                   bg_rgb,
    input  logic [NUM_LAYERS-1:0]         lay_en,
    input  logic [NUM_LAYERS-1:0]         lay_pipe,
    input  logic [NUM_LAYERS*PRIO_W-1:0]  lay_prio,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_x,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_y,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_w,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_h,
    input  logic [NUM_LAYERS*32-1:0]      lay_argb,
    output logic                          pix_valid,
    output logic [COORD_W-1:0]            pix_x,
    output logic [COORD_W-1:0]            pix_y,
    output logic                          out_valid,
    output logic                          out_last,
    output logic [COORD_W-1:0]            out_x,
    output logic [COORD_W-1:0]            out_y,
    output logic [23:0]                   out_rgb
);
    typedef struct packed {
        logic                         valid;
        logic                         last;
        logic [COORD_W-1:0]           x;
        logic [COORD_W-1:0]           y;
        logic [NUM_PIPES-1:0]         hit;
        argb_t [NUM_PIPES-1:0]        px;
    } resolve_t;

    typedef struct packed {
        logic               valid;
        logic               last;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        rgb_t               rgb;
    } emit_t;

    typedef struct packed {
        rgb_t     bg;
        resolve_t s1;
        emit_t    s2;
    } state_t;

    state_t st_d, st_q;

    // Coordinate generator
    logic scan_last;

    lc_scan #(.COORD_W(COORD_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .disp_w   (disp_w),
        .disp_h   (disp_h),
        .pix_valid(pix_valid),
        .pix_last (scan_last),
        .pix_x    (pix_x),
        .pix_y    (pix_y)
    );

    // Per-pipe priority resolution
    logic [NUM_PIPES-1:0]  pipe_hit;
    argb_t [NUM_PIPES-1:0] pipe_px;

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        lc_pipe_resolve #(
            .NUM_LAYERS    (NUM_LAYERS),
            .COORD_W       (COORD_W),
            .PRIO_W        (PRIO_W),
            .PIPE_SEL      (p == 1),
            .DROP_LOW_ALPHA(p == 0)
        ) u_res (
            .lay_en  (lay_en),
            .lay_pipe(lay_pipe),
            .lay_prio(lay_prio),
            .lay_x   (lay_x),
            .lay_y   (lay_y),
            .lay_w   (lay_w),
            .lay_h   (lay_h),
            .lay_argb(lay_argb),
            .pos_x   (pix_x),
            .pos_y   (pix_y),
            .hit     (pipe_hit[p]),
            .px      (pipe_px[p])
        );
    end

    // Bottom-up blend chain: background, then pipe 0, then pipe 1.
    rgb_t            layer_acc [NUM_PIPES+1];
    rgb_t            layer_mix [NUM_PIPES];
    logic [CH_W-1:0] eff_alpha [NUM_PIPES];

    assign layer_acc[0] = st_q.bg;

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_mix
        // The bottom pipe is drawn opaque.
        assign eff_alpha[p] = (p == 0) ? ALPHA_OPAQUE : st_q.s1.px[p].a;

        lc_blend u_blend (
            .alpha(eff_alpha[p]),
            .upper(rgb_t'({st_q.s1.px[p].r, st_q.s1.px[p].g, st_q.s1.px[p].b})),
            .lower(layer_acc[p]),
            .mix  (layer_mix[p])
        );

        assign layer_acc[p+1] = st_q.s1.hit[p] ? layer_mix[p] : layer_acc[p];
    end

    always_comb begin
        st_d = st_q;

        if (bg_wr) begin
            st_d.bg = rgb_t'(bg_rgb);
        end

        st_d.s1.valid = pix_valid;
        st_d.s1.last  = scan_last;
        st_d.s1.x     = pix_x;
        st_d.s1.y     = pix_y;
        st_d.s1.hit   = pipe_hit;
        st_d.s1.px    = pipe_px;

        st_d.s2.valid = st_q.s1.valid;
        st_d.s2.last  = st_q.s1.last;
        st_d.s2.x     = st_q.s1.x;
        st_d.s2.y     = st_q.s1.y;
        st_d.s2.rgb   = layer_acc[NUM_PIPES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.s2.valid;
    assign out_last  = st_q.s2.last;
    assign out_x     = st_q.s2.x;
    assign out_y     = st_q.s2.y;
    assign out_rgb   = st_q.s2.rgb;
endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
    parameter int COORD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_valid,
    input logic               out_valid,
    input logic               out_last,
    input logic [COORD_W-1:0] out_x,
    input logic [COORD_W-1:0] out_y,
    input logic [COORD_W-1:0] disp_w,
    input logic [COORD_W-1:0] disp_h
);
    localparam logic [COORD_W-1:0] ONE = 1;

    AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R2

    AST_X_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_x < disp_w)); // R2

    AST_Y_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_y < disp_h)); // R2

    AST_RASTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(out_last)) |->
        ((out_x == $past(out_x) + ONE && out_y == $past(out_y)) ||
         (out_x == '0 && out_y == $past(out_y) + ONE))); // R2

    AST_TWO_STAGE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(pix_valid, 2)); // R10
endmodule

bind layer_compositor lc_checker #(.COORD_W(COORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_valid(pix_valid),
    .out_valid(out_valid),
    .out_last (out_last),
    .out_x    (out_x),
    .out_y    (out_y),
    .disp_w   (disp_w),
    .disp_h   (disp_h)
);

// File: tb/sim_layer_compositor.sv
module sim_layer_compositor;
    localparam int NL = 4;
    localparam int CW = 8;
    localparam int PW = 2;
    localparam int DW = 8;
    localparam int DH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [CW-1:0]   disp_w = CW'(DW);
    logic [CW-1:0]   disp_h = CW'(DH);
    logic            bg_wr = 1'b0;
    logic [23:0]     bg_rgb = '0;
    logic [NL-1:0]   lay_en = '0;
    logic [NL-1:0]   lay_pipe = '0;
    logic [NL*PW-1:0] lay_prio = '0;
    logic [NL*CW-1:0] lay_x, lay_y, lay_w, lay_h;
    logic [NL*32-1:0] lay_argb;
    logic [31:0]     alphas = 32'hFFFFFFFF;
    logic            pix_valid, out_valid, out_last;
    logic [CW-1:0]   pix_x, pix_y, out_x, out_y;
    logic [23:0]     out_rgb;

    // Fixed geometry (layer 3 .. layer 0): L0 full frame, L1 x2..5 y0..1,
    // L2 x4..7 y1..3, L3 x0..2 y2..3.
    assign lay_x = {8'd0, 8'd4, 8'd2, 8'd0};
    assign lay_y = {8'd2, 8'd1, 8'd0, 8'd0};
    assign lay_w = {8'd3, 8'd4, 8'd4, 8'd8};
    assign lay_h = {8'd2, 8'd3, 8'd2, 8'd4};
    assign lay_argb = {alphas[31:24], 24'h00FF00, alphas[23:16], 24'hC08040,
                       alphas[15:8],  24'h405060, alphas[7:0],   24'h102030};

    layer_compositor #(.NUM_LAYERS(NL), .COORD_W(CW), .PRIO_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .disp_w(disp_w), .disp_h(disp_h),
        .bg_wr(bg_wr), .bg_rgb(bg_rgb), .lay_en(lay_en), .lay_pipe(lay_pipe),
        .lay_prio(lay_prio), .lay_x(lay_x), .lay_y(lay_y), .lay_w(lay_w),
        .lay_h(lay_h), .lay_argb(lay_argb), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_y(pix_y), .out_valid(out_valid), .out_last(out_last), .out_x(out_x),
        .out_y(out_y), .out_rgb(out_rgb)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected<=100000 cycles", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]  tag;
        logic [3:0]  en;
        logic [3:0]  pipe;
        logic [7:0]  prio;
        logic [31:0] alph;
        logic [7:0]  px;
        logic [7:0]  py;
        logic [23:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 4'b0001, 4'b0000, 8'h00, 32'hFFFFFFFF, 8'd5, 8'd3, 24'h102030}, // R3 single layer
        '{4'd5, 4'b0000, 4'b0000, 8'h00, 32'hFFFFFFFF, 8'd0, 8'd0, 24'h000000}, // R5 nothing enabled
        '{4'd4, 4'b0011, 4'b0000, 8'h09, 32'hFFFFFFFF, 8'd3, 8'd1, 24'h405060}, // R4 L1 higher
        '{4'd4, 4'b0011, 4'b0000, 8'h01, 32'hFFFFFFFF, 8'd3, 8'd1, 24'h102030}, // R4 L0 higher
        '{4'd4, 4'b0011, 4'b0000, 8'h05, 32'hFFFFFFFF, 8'd3, 8'd1, 24'h102030}, // R4 tie, low index
        '{4'd3, 4'b0011, 4'b0000, 8'h09, 32'hFFFFFFFF, 8'd6, 8'd1, 24'h102030}, // R3 right edge excluded
        '{4'd6, 4'b0101, 4'b0100, 8'h00, 32'hFFFFFFFF, 8'd5, 8'd2, 24'hC08040}, // R6 alpha 255
        '{4'd6, 4'b0101, 4'b0100, 8'h00, 32'hFF00FFFF, 8'd5, 8'd2, 24'h102030}, // R6 alpha 0
        '{4'd6, 4'b0101, 4'b0100, 8'h00, 32'hFF80FFFF, 8'd5, 8'd2, 24'h685038}, // R6 alpha 128
        '{4'd7, 4'b0001, 4'b0000, 8'h00, 32'hFFFFFF80, 8'd0, 8'd0, 24'h000000}, // R7 quirk alone
        '{4'd8, 4'b0001, 4'b0000, 8'h01, 32'hFFFFFF80, 8'd0, 8'd0, 24'h102030}, // R8 alpha ignored
        '{4'd3, 4'b0001, 4'b0000, 8'h0D, 32'hFFFFFFFF, 8'd3, 8'd1, 24'h102030}, // R3 disabled L1
        '{4'd7, 4'b0101, 4'b0100, 8'h00, 32'hFF80FF80, 8'd5, 8'd2, 24'h604020}, // R7 quirk under pipe 1
        '{4'd5, 4'b0101, 4'b0100, 8'h00, 32'hFFFFFFFF, 8'd0, 8'd0, 24'h102030}, // R5 pipe 1 empty
        '{4'd6, 4'b0011, 4'b0010, 8'h03, 32'hFFFFFFFF, 8'd3, 8'd1, 24'h405060}  // R6 pipe 1 on top
    };

    int          npix;
    int          order_err;
    logic [23:0] probe_rgb;
    logic [7:0]  last_x, last_y;

    task automatic run_frame(input int inject, input logic [7:0] px, input logic [7:0] py);
        int  ex = 0;
        int  ey = 0;
        bit  done = 0;
        npix = 0;
        order_err = 0;
        probe_rgb = 'x;
        last_x = 'x;
        last_y = 'x;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 300 && !done; c++) begin
            start = 1'b0;
            if (out_valid) begin
                if (out_x !== 8'(ex) || out_y !== 8'(ey)) order_err++;
                if (out_x == px && out_y == py) probe_rgb = out_rgb;
                last_x = out_x;
                last_y = out_y;
                if (npix == inject) start = 1'b1;
                npix++;
                if (out_last) done = 1;
                ex++;
                if (ex == DW) begin ex = 0; ey++; end
            end
            if (!done) @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 out_last", 32'(out_last), 32'd0);
        chk("R1 pix_valid", 32'(pix_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: default black background with nothing enabled
        lay_en = '0;
        run_frame(-1, 8'd4, 8'd2);
        chk("R1 default bg", 32'(probe_rgb), 32'h000000);

        for (int v = 0; v < NV; v++) begin
            lay_en   = VECS[v].en;
            lay_pipe = VECS[v].pipe;
            lay_prio = VECS[v].prio;
            alphas   = VECS[v].alph;
            run_frame(-1, VECS[v].px, VECS[v].py);
            checks++;
            if (probe_rgb !== VECS[v].exp) begin
                errors++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VECS[v].tag, v, probe_rgb, VECS[v].exp);
            end
        end

        // R10: two edges from coordinate to output
        lay_en = '0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R10 pix_valid", 32'(pix_valid), 32'd1);
        chk("R10 out early 1", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R10 out early 2", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R10 out valid", 32'(out_valid), 32'd1);
        chk("R10 out coord", {out_x, out_y}, 32'd0);
        repeat (40) @(negedge clk);

        // R2: raster order, restart request mid-frame ignored
        run_frame(10, 8'd0, 8'd0);
        chk("R2 pixel count", 32'(npix), 32'(DW * DH));
        chk("R2 order", 32'(order_err), 32'd0);
        chk("R2 last coord", {last_x, last_y}, {8'd7, 8'd3});
        begin
            int extra = 0;
            repeat (12) begin
                @(negedge clk);
                if (out_valid) extra++;
            end
            chk("R2 no restart", 32'(extra), 32'd0);
        end

        // R2: zero-width frame ignored
        disp_w = '0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        begin
            int seen = 0;
            repeat (10) begin
                @(negedge clk);
                if (out_valid || pix_valid) seen++;
            end
            chk("R2 zero size", 32'(seen), 32'd0);
        end
        disp_w = CW'(DW);

        // R9: background load
        @(negedge clk); bg_wr = 1'b1; bg_rgb = 24'h0A0B0C;
        @(negedge clk); bg_wr = 1'b0; bg_rgb = 24'hFFFFFF;
        lay_en = '0;
        run_frame(-1, 8'd2, 8'd2);
        chk("R9 bg loaded", 32'(probe_rgb), 32'h0A0B0C);

        // R7: discarded translucent pixel reveals the loaded background
        lay_en = 4'b0001; lay_pipe = '0; lay_prio = 8'h00; alphas = 32'hFFFFFF80;
        run_frame(-1, 8'd0, 8'd0);
        chk("R7 quirk bg", 32'(probe_rgb), 32'h0A0B0C);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule